// File: doc/BRIEF.md
# Indexed Interrupt Source Bank

This block keeps the configuration and the pending state for a large set of interrupt inputs. Software reaches it through a small register window. A select register names one source. The mode, vector and command registers then act on that source only. Each source has a priority, a trigger type, a 32-bit vector word, an enable bit and a pending bit. A detector on each raw input turns the programmed level or edge into pending state.

Three sets of values are driven to the downstream arbiter and vectoring logic: the sources that are both pending and enabled, the priority of every source, and the vector of every source. The arbiter and the processor handshake are outside this block. Pending state can be read as packed 32-bit words, so software can sweep every source without changing the select register.

The bus port is a plain synchronous request port. A write takes effect at the clock edge where the request is sampled. The read data is registered.

Top module: `irq_src_bank`

## Requirements
- R1: A write to offset 0x00 loads the select register from write data bits [6:0]. A read of 0x00 returns the selection zero-extended. The selection holds until the next write to 0x00.
- R2: A write to offset 0x04 sets the priority (bits [2:0], 0 lowest to 7 highest) and the trigger type (bits [6:5]) of the selected source only. A read of 0x04 returns those two fields in the same positions, with all other bits 0.
- R3: A write to offset 0x08 sets the 32-bit vector of the selected source only. A read of 0x08 returns that vector.
- R4: The trigger type codes are 0 = level active low, 1 = falling edge, 2 = level active high, 3 = rising edge. An edge is found by comparing the input with the value sampled at the previous clock. Pending is set at the clock edge where the new input value is sampled.
- R5: For the two level types, pending equals the asserted state of the input as sampled at the last clock. The clear and set commands have no effect on a level source.
- R6: For the two edge types, a write to 0x48 clears pending and a write to 0x4C forces pending. Pending otherwise stays set until it is cleared.
- R7: A write to 0x40 enables the selected source and a write to 0x44 disables it. A read of 0x30 returns the enable bit of the selected source in bit 0, with all other bits 0.
- R8: A write to a command register (0x40, 0x44, 0x48, 0x4C) acts only when write data bit 0 is 1. It acts only on the selected source.
- R9: Reads of 0x20, 0x24, 0x28 and 0x2C return the pending bits. Bit b of word k is source 32*k+b.
- R10: active_o bit i is source i's pending bit ANDed with its enable bit. prio_o[3i+2:3i] carries the priority of source i. vec_o[32i+31:32i] carries its vector.
- R11: After reset the selection is 0, every source is disabled and not pending, every priority, trigger type and vector is 0, and rdata_o is 0.
- R12: rdata_o updates at the clock edge that samples a read request, with the value from before that edge. Without a read request it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| src_i | input | 128 | Raw interrupt inputs, one per source |
| active_o | output | 128 | Sources that are pending and enabled |
| prio_o | output | 384 | Priority of every source, 3 bits each |
| vec_o | output | 4096 | Vector word of every source, 32 bits each |

## Verification
The assertions assume that the raw inputs are already synchronous to clk_i and change at most once per clock. They also assume that the bus signals are stable around the sampling edge. The bench drives src_i, req_i, we_i, addr_i and wdata_i only on falling clock edges, one source and one access at a time, so no edge and no command share a clock. The random phase draws source indices, offsets and data only from the register map, and idle cycles separate accesses. Mode changes therefore settle before the next check.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  typedef enum logic [1:0] {
    TRIG_LVL_LOW   = 2'd0,
    TRIG_EDGE_FALL = 2'd1,
    TRIG_LVL_HIGH  = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_e;

  localparam logic [7:0] OFF_SEL   = 8'h00;
  localparam logic [7:0] OFF_MODE  = 8'h04;
  localparam logic [7:0] OFF_VEC   = 8'h08;
  localparam logic [7:0] OFF_PEND0 = 8'h20;
  localparam logic [7:0] OFF_MASK  = 8'h30;
  localparam logic [7:0] OFF_EN    = 8'h40;
  localparam logic [7:0] OFF_DIS   = 8'h44;
  localparam logic [7:0] OFF_CLR   = 8'h48;
  localparam logic [7:0] OFF_SET   = 8'h4C;

  localparam int PRIO_W = 3;

  typedef struct packed {
    logic mode;
    logic vec;
    logic en;
    logic dis;
    logic clr;
    logic set;
  } cmd_t;
endpackage

// File: rtl/irq_reg_if.sv
module irq_reg_if
  import irq_bank_pkg::*;
#(
  parameter int N_SRC  = 128,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(N_SRC),
  localparam int NW    = N_SRC / DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [IDX_W-1:0]  sel_o,
  output cmd_t              cmd_o,
  input  logic [PRIO_W-1:0] sel_prio_i,
  input  trig_e             sel_type_i,
  input  logic [DATA_W-1:0] sel_vec_i,
  input  logic              sel_en_i,
  input  logic [N_SRC-1:0]  pend_i
);
  logic [IDX_W-1:0]  sel_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic              wr, rd;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (wr && addr_i == ADDR_W'(OFF_SEL)) sel_q <= wdata_i[IDX_W-1:0];
  end

  // command strobes need bit 0 set
  always_comb begin
    cmd_o      = '0;
    cmd_o.mode = wr && addr_i == ADDR_W'(OFF_MODE);
    cmd_o.vec  = wr && addr_i == ADDR_W'(OFF_VEC);
    cmd_o.en   = wr && wdata_i[0] && addr_i == ADDR_W'(OFF_EN);
    cmd_o.dis  = wr && wdata_i[0] && addr_i == ADDR_W'(OFF_DIS);
    cmd_o.clr  = wr && wdata_i[0] && addr_i == ADDR_W'(OFF_CLR);
    cmd_o.set  = wr && wdata_i[0] && addr_i == ADDR_W'(OFF_SET);
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(OFF_SEL))  rd_mux = DATA_W'(sel_q);
    if (addr_i == ADDR_W'(OFF_MODE)) rd_mux = DATA_W'({sel_type_i, 2'b00, sel_prio_i});
    if (addr_i == ADDR_W'(OFF_VEC))  rd_mux = sel_vec_i;
    if (addr_i == ADDR_W'(OFF_MASK)) rd_mux = DATA_W'(sel_en_i);
    for (int w = 0; w < NW; w++) begin
      if (addr_i == ADDR_W'(OFF_PEND0) + ADDR_W'(4 * w)) rd_mux = pend_i[w*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign sel_o   = sel_q;
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_i,
  input  logic              wr_mode_i,
  input  logic              wr_vec_i,
  input  logic              en_cmd_i,
  input  logic              dis_cmd_i,
  input  logic              clr_cmd_i,
  input  logic              set_cmd_i,
  input  logic [PRIO_W-1:0] prio_wr_i,
  input  trig_e             type_wr_i,
  input  logic [DATA_W-1:0] vec_wr_i,
  output logic [PRIO_W-1:0] prio_o,
  output trig_e             type_o,
  output logic [DATA_W-1:0] vec_o,
  output logic              en_o,
  output logic              pend_o
);
  logic [PRIO_W-1:0] prio_q;
  trig_e             type_q;
  logic [DATA_W-1:0] vec_q;
  logic              en_q, pend_q, prev_q;
  logic              is_edge, edge_hit, lvl_hit, pend_d;

  assign is_edge  = type_q[0];
  assign edge_hit = (type_q == TRIG_EDGE_RISE &&  src_i && !prev_q) ||
                    (type_q == TRIG_EDGE_FALL && !src_i &&  prev_q);
  assign lvl_hit  = (type_q == TRIG_LVL_HIGH) ? src_i : !src_i;

  always_comb begin
    if (!is_edge)                  pend_d = lvl_hit;
    else if (edge_hit || set_cmd_i) pend_d = 1'b1;
    else if (clr_cmd_i)             pend_d = 1'b0;
    else                            pend_d = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      type_q <= TRIG_LVL_LOW;
      vec_q  <= '0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= src_i;
      pend_q <= pend_d;
      if (wr_mode_i) begin
        prio_q <= prio_wr_i;
        type_q <= type_wr_i;
      end
      if (wr_vec_i) vec_q <= vec_wr_i;
      if (en_cmd_i)       en_q <= 1'b1;
      else if (dis_cmd_i) en_q <= 1'b0;
    end
  end

  assign prio_o = prio_q;
  assign type_o = type_q;
  assign vec_o  = vec_q;
  assign en_o   = en_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_bank_pkg::*;
#(
  parameter int N_SRC  = 128,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  input  logic [N_SRC-1:0]         src_i,
  output logic [N_SRC-1:0]         active_o,
  output logic [N_SRC*PRIO_W-1:0]  prio_o,
  output logic [N_SRC*DATA_W-1:0]  vec_o
);
  logic [IDX_W-1:0]  sel_q;
  cmd_t              cmd;
  logic [PRIO_W-1:0] prio_a [N_SRC];
  trig_e             type_a [N_SRC];
  logic [DATA_W-1:0] vec_a  [N_SRC];
  logic [N_SRC-1:0]  en_v, pend_v;

  irq_reg_if #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_reg_if (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .sel_o      (sel_q),
    .cmd_o      (cmd),
    .sel_prio_i (prio_a[sel_q]),
    .sel_type_i (type_a[sel_q]),
    .sel_vec_i  (vec_a[sel_q]),
    .sel_en_i   (en_v[sel_q]),
    .pend_i     (pend_v)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic hit;
    assign hit = (sel_q == IDX_W'(i));

    irq_src_cell #(.DATA_W(DATA_W)) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (src_i[i]),
      .wr_mode_i (hit & cmd.mode),
      .wr_vec_i  (hit & cmd.vec),
      .en_cmd_i  (hit & cmd.en),
      .dis_cmd_i (hit & cmd.dis),
      .clr_cmd_i (hit & cmd.clr),
      .set_cmd_i (hit & cmd.set),
      .prio_wr_i (wdata_i[PRIO_W-1:0]),
      .type_wr_i (trig_e'(wdata_i[6:5])),
      .vec_wr_i  (wdata_i),
      .prio_o    (prio_a[i]),
      .type_o    (type_a[i]),
      .vec_o     (vec_a[i]),
      .en_o      (en_v[i]),
      .pend_o    (pend_v[i])
    );

    assign prio_o[i*PRIO_W +: PRIO_W] = prio_a[i];
    assign vec_o[i*DATA_W +: DATA_W]  = vec_a[i];
  end

  assign active_o = pend_v & en_v;
endmodule

// File: rtl/irq_src_bank_chk.sv
module irq_src_bank_chk
  import irq_bank_pkg::*;
#(
  parameter int N_SRC  = 128,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_i,
  input logic                    we_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [DATA_W-1:0]       wdata_i,
  input logic [DATA_W-1:0]       rdata_o,
  input logic [IDX_W-1:0]        sel_i,
  input logic [N_SRC-1:0]        active_o,
  input logic [N_SRC*PRIO_W-1:0] prio_o
);
  logic [PRIO_W-1:0] prio_s [N_SRC];
  for (genvar i = 0; i < N_SRC; i++) begin : g_split
    assign prio_s[i] = prio_o[i*PRIO_W +: PRIO_W];
  end

  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i == ADDR_W'(OFF_SEL)) |=> $stable(sel_i)); // R1

  AST_PRIO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(OFF_MODE))
      |=> prio_s[$past(sel_i)] == $past(wdata_i[PRIO_W-1:0])); // R2

  AST_DISABLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && wdata_i[0] && addr_i == ADDR_W'(OFF_DIS))
      |=> !active_o[$past(sel_i)]); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o)); // R12
endmodule

bind irq_src_bank irq_src_bank_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .sel_i    (sel_q),
  .active_o (active_o),
  .prio_o   (prio_o)
);

// File: tb/irq_src_bank_tb.sv
module irq_src_bank_tb;
  localparam int N = 128;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           req_i = 1'b0, we_i = 1'b0;
  logic [7:0]     addr_i = '0;
  logic [31:0]    wdata_i = '0;
  logic [31:0]    rdata_o;
  logic [N-1:0]   src_i = '1;
  logic [N-1:0]   active_o;
  logic [N*3-1:0] prio_o;
  logic [N*32-1:0] vec_o;

  int checks = 0, failures = 0;

  logic [6:0]  m_sel;
  logic [2:0]  m_prio [N];
  logic [1:0]  m_type [N];
  logic [31:0] m_vec  [N];
  logic [N-1:0] m_en, m_pend;

  always #2.5 clk_i = ~clk_i;

  irq_src_bank u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void refresh_lvl();
    for (int i = 0; i < N; i++)
      if (!m_type[i][0]) m_pend[i] = (m_type[i] == 2'd2) ? src_i[i] : !src_i[i];
  endfunction

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); req_i = 0; we_i = 0;
    @(negedge clk_i);
    case (a)
      8'h00: m_sel = d[6:0];
      8'h04: begin m_prio[m_sel] = d[2:0]; m_type[m_sel] = d[6:5]; end
      8'h08: m_vec[m_sel] = d;
      8'h40: if (d[0]) m_en[m_sel] = 1'b1;
      8'h44: if (d[0]) m_en[m_sel] = 1'b0;
      8'h48: if (d[0] && m_type[m_sel][0]) m_pend[m_sel] = 1'b0;
      8'h4C: if (d[0] && m_type[m_sel][0]) m_pend[m_sel] = 1'b1;
      default: ;
    endcase
    refresh_lvl();
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk_i); req_i = 0;
    d = rdata_o;
  endtask

  task automatic drive_src(int i, logic v);
    logic old;
    old = src_i[i];
    @(negedge clk_i); src_i[i] = v;
    @(negedge clk_i);
    if (old !== v) begin
      if (m_type[i] == 2'd3 && v)  m_pend[i] = 1'b1;
      if (m_type[i] == 2'd1 && !v) m_pend[i] = 1'b1;
    end
    refresh_lvl();
  endtask

  task automatic check_outputs(string req);
    for (int i = 0; i < N; i++) begin
      check({req, " R10 active"}, 32'(active_o[i]), 32'(m_pend[i] & m_en[i]));
      check({req, " R10 prio"}, 32'(prio_o[i*3 +: 3]), 32'(m_prio[i]));
      check({req, " R10 vec"}, vec_o[i*32 +: 32], m_vec[i]);
    end
  endtask

  task automatic check_regs(string req);
    logic [31:0] d;
    for (int w = 0; w < 4; w++) begin
      bus_rd(8'h20 + 8'(4 * w), d);
      check({req, " R9 pend word"}, d, m_pend[w*32 +: 32]);
    end
    bus_rd(8'h04, d);
    check({req, " R2 mode"}, d, {25'd0, m_type[m_sel], 2'b00, m_prio[m_sel]});
    bus_rd(8'h30, d);
    check({req, " R7 mask"}, d, 32'(m_en[m_sel]));
    bus_rd(8'h00, d);
    check({req, " R1 sel"}, d, 32'(m_sel));
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog R11 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    m_sel = '0; m_en = '0; m_pend = '0;
    for (int i = 0; i < N; i++) begin m_prio[i] = '0; m_type[i] = '0; m_vec[i] = '0; end
    repeat (4) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R11 reset state
    check("R11 rdata", rdata_o, 32'd0);
    check("R11 active", active_o[31:0] | active_o[127:96], 32'd0);
    check_outputs("R11");
    check_regs("R11");

    // R1 R2 mode on source 5
    bus_wr(8'h00, 32'hFFFF_FF85);
    bus_rd(8'h00, d); check("R1 sel low bits", d, 32'd5);
    bus_wr(8'h04, 32'h0000_0066);
    bus_rd(8'h04, d); check("R2 mode readback", d, 32'h66);
    check("R2 other source", 32'(prio_o[6*3 +: 3]), 32'd0);
    // R3 vectors
    bus_wr(8'h08, 32'hCAFE_0005);
    bus_wr(8'h00, 32'd6);
    bus_wr(8'h08, 32'h1234_0006);
    check("R3 sel5 vec kept", vec_o[5*32 +: 32], 32'hCAFE_0005);
    bus_rd(8'h08, d); check("R3 vec readback", d, 32'h1234_0006);

    // R4 rising edge on 5
    bus_wr(8'h00, 32'd5);
    drive_src(5, 1'b0);
    bus_rd(8'h20, d); check("R4 no pend on fall", d[5], 1'b0);
    drive_src(5, 1'b1);
    bus_rd(8'h20, d); check("R4 rise pends", d[5], 1'b1);
    check("R10 disabled not active", active_o[5], 1'b0);
    bus_wr(8'h40, 32'd1);
    check("R7 enable active", active_o[5], 1'b1);
    // R8 command ignored when bit0 = 0
    bus_wr(8'h48, 32'hFFFF_FFFE);
    check("R8 clr ignored", active_o[5], 1'b1);
    // R6 clear and set
    bus_wr(8'h48, 32'd1);
    check("R6 clear", active_o[5], 1'b0);
    bus_wr(8'h4C, 32'd1);
    check("R6 set", active_o[5], 1'b1);
    // R7 disable
    bus_wr(8'h44, 32'd1);
    check("R7 disable", active_o[5], 1'b0);
    bus_rd(8'h30, d); check("R7 mask zero", d, 32'd0);

    // R5 high level on 100
    bus_wr(8'h00, 32'd100);
    bus_wr(8'h04, 32'h0000_0043);
    bus_wr(8'h40, 32'd1);
    drive_src(100, 1'b0);
    check("R5 level low idle", active_o[100], 1'b0);
    drive_src(100, 1'b1);
    bus_rd(8'h2C, d); check("R5 R9 level pend word3", d[4], 1'b1);
    bus_wr(8'h48, 32'd1);
    check("R5 clr ignored", active_o[100], 1'b1);
    drive_src(100, 1'b0);
    check("R5 follows level", active_o[100], 1'b0);
    bus_wr(8'h4C, 32'd1);
    check("R5 set ignored", active_o[100], 1'b0);

    // R4 falling edge on 127
    bus_wr(8'h00, 32'd127);
    bus_wr(8'h04, 32'h0000_0027);
    bus_wr(8'h40, 32'd1);
    check("R4 falling idle", active_o[127], 1'b0);
    drive_src(127, 1'b0);
    check("R4 falling pends", active_o[127], 1'b1);
    drive_src(127, 1'b1);
    check("R6 edge held", active_o[127], 1'b1);
    check_outputs("directed");
    check_regs("directed");

    // random phase
    void'($urandom(32'd20240607));
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom_range(0, 7);
      case (op)
        0: bus_wr(8'h00, 32'($urandom_range(0, N - 1)) | ($urandom() & 32'hFFFF_FF00));
        1: bus_wr(8'h04, $urandom());
        2: bus_wr(8'h08, $urandom());
        3: bus_wr(8'h40, $urandom());
        4: bus_wr(8'h44, $urandom());
        5: bus_wr(8'h48, $urandom());
        6: bus_wr(8'h4C, $urandom());
        default: begin
          int k;
          k = $urandom_range(0, N - 1);
          drive_src(k, ~src_i[k]);
        end
      endcase
      check("R10 R4 R5 R6 active vector", 32'(active_o == (m_pend & m_en)), 32'd1);
      if (n % 25 == 0) begin
        check_outputs("random");
        check_regs("random");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule